// File: doc/BRIEF.md
# DMA End-of-Transfer Controller

This block paces byte-wide DMA traffic between a bulk endpoint buffer and an external DMA engine. It uses a request/acknowledge handshake. While a transfer is armed and the buffer holds bytes, the block raises a request. Each cycle in which the acknowledge is high while the request is high moves one byte, and the acknowledge alone strobes that byte. The byte goes from the buffer read port onto the 8-bit DMA data bus, and the block pops it from the buffer.

Software programs a 16-bit byte count and three control bits: transfer enable, end-on-count and end-on-short-packet. Setting the enable loads an internal down-counter from the byte count. The transfer then runs until one of the armed conditions ends it:
- the counter runs out;
- a short packet has been fully moved;
- software clears the enable.

On the end, the block drops the request and clears the enable. It gives a one-cycle pulse and sets a sticky flag, which software clears by writing one. A cause field records every condition that fired.

Packet arrival is modelled as a strobe with a length. A packet shorter than the maximum packet size is a short packet.

Top module: `dma_eot_ctrl`

## Requirements
- R1: After reset, dreq, eot_flag, eot_pulse, eot_cause, cfg_en and bytes_left are all zero.
- R2: A cfg write with bit 0 (enable) set while cfg_en is low loads bytes_left from the stored byte count. A write with enable set while cfg_en is already high does not reload it. cfg_wdata bit 1 arms end-on-count and bit 2 arms end-on-short-packet.
- R3: dreq is high exactly when cfg_en is high, the current packet still has bytes left, and end-on-count is not armed with bytes_left at zero.
- R4: A cycle with dack and dreq both high moves one byte. In that cycle buf_pop is high and dma_data equals buf_rdata, and bytes_left is one lower after the edge. dack while dreq is low moves nothing and leaves bytes_left unchanged.
- R5: With end-on-count armed, the byte that takes bytes_left from 1 to 0 ends the transfer. After that edge eot_pulse and eot_flag are high, eot_cause bit 0 is set, and cfg_en and dreq are low.
- R6: With end-on-count clear, bytes_left keeps counting down through zero, wrapping to all ones, and never ends the transfer.
- R7: With end-on-count armed and a byte count of zero, the transfer ends one cycle after the enabling write, and dreq is never raised.
- R8: With end-on-short-packet armed, a packet of length below MAX_PKT ends the transfer after its last byte moves, and sets eot_cause bit 1. A zero-length packet ends it on the edge that takes the strobe. Packets of full size never end it.
- R9: A pkt_valid strobe that arrives while the current packet still has bytes left is ignored.
- R10: A cfg write with enable clear while cfg_en is high ends the transfer and sets eot_cause bit 2.
- R11: When several conditions fire on the same cycle, one single-cycle eot_pulse is produced and eot_cause holds every cause bit that fired.
- R12: eot_flag and eot_cause hold until eot_clr is high at an edge, which clears both. A new end on the same edge as eot_clr wins, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_wdata | input | 3 | {end-on-short, end-on-count, enable} |
| cnt_we | input | 1 | Byte count write strobe |
| cnt_wdata | input | CNT_W | Byte count value |
| eot_clr | input | 1 | Write-one-to-clear for the end flag and cause |
| pkt_valid | input | 1 | New packet present in endpoint buffer |
| pkt_len | input | LEN_W | Length of that packet in bytes |
| buf_rdata | input | 8 | Byte at the head of the endpoint buffer |
| buf_pop | output | 1 | Head byte consumed this cycle |
| dack | input | 1 | DMA acknowledge, strobes one byte |
| dreq | output | 1 | DMA request |
| dma_data | output | 8 | Byte driven to the DMA engine |
| cfg_en | output | 1 | Current enable bit |
| eot_flag | output | 1 | Sticky end-of-transfer flag |
| eot_pulse | output | 1 | One-cycle end-of-transfer pulse |
| eot_cause | output | 3 | {software, short packet, count} |
| bytes_left | output | CNT_W | Internal down-counter |

## Verification
dreq, buf_pop and dma_data are combinational from registered state and dack. The bench reads them after the inputs settle and before the next edge. bytes_left, cfg_en, eot_flag, eot_pulse and eot_cause are registered. Each is due one edge after the write, strobe or final byte that causes it, so the bench steps one edge and samples one time unit later. The zero-count case is the exception: its end appears one edge after the enable itself lands, and the bench waits that extra edge before expecting the flag.

// File: rtl/dma_eot_pkg.sv
`timescale 1ns/1ps
package dma_eot_pkg;
    typedef struct packed {
        logic short_en;
        logic cnt_en;
        logic en;
    } dma_cfg_t;

    typedef struct packed {
        logic sw;
        logic shrt;
        logic cnt;
    } eot_cause_t;
endpackage

// File: rtl/dma_byte_cnt.sv
`timescale 1ns/1ps
module dma_byte_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             is_zero,
    output logic             is_one
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = load_val;
        end else if (dec) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count   = st_q.cnt;
    assign is_zero = (st_q.cnt == '0);
    assign is_one  = (st_q.cnt == CNT_W'(1));
endmodule

// File: rtl/dma_pkt_track.sv
`timescale 1ns/1ps
module dma_pkt_track #(
    parameter int MAX_PKT = 64,
    parameter int LEN_W   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_valid,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic             take,
    output logic             has_data,
    output logic             last_short,
    output logic             zlp_short
);
    typedef struct packed {
        logic [LEN_W-1:0] left;
        logic             short_pkt;
    } trk_st_t;

    trk_st_t st_d, st_q;
    logic    accept;

    // a new packet is taken only once the previous one is drained
    assign accept = pkt_valid && (st_q.left == '0);

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.left      = pkt_len;
            st_d.short_pkt = (pkt_len < LEN_W'(MAX_PKT));
        end else if (take && (st_q.left != '0)) begin
            st_d.left = st_q.left - LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign has_data   = (st_q.left != '0);
    assign last_short = st_q.short_pkt && (st_q.left == LEN_W'(1));
    assign zlp_short  = accept && (pkt_len == '0);
endmodule

// File: rtl/dma_eot_decide.sv
`timescale 1ns/1ps
module dma_eot_decide
    import dma_eot_pkg::*;
(
    input  logic       active,
    input  logic       cnt_en,
    input  logic       short_en,
    input  logic       sw_stop,
    input  logic       beat,
    input  logic       cnt_zero,
    input  logic       cnt_one,
    input  logic       last_short,
    input  logic       zlp_short,
    output eot_cause_t cause,
    output logic       fire
);
    always_comb begin
        cause      = '0;
        cause.cnt  = active && cnt_en && (cnt_zero || (beat && cnt_one));
        cause.shrt = active && short_en && ((beat && last_short) || zlp_short);
        cause.sw   = active && sw_stop;
        fire       = cause.cnt || cause.shrt || cause.sw;
    end
endmodule

// File: rtl/dma_eot_ctrl.sv
`timescale 1ns/1ps
module dma_eot_ctrl
    import dma_eot_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int DATA_W  = 8,
    parameter int MAX_PKT = 64,
    localparam int LEN_W  = $clog2(MAX_PKT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_wdata,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              eot_clr,
    input  logic              pkt_valid,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic [DATA_W-1:0] buf_rdata,
    output logic              buf_pop,
    input  logic              dack,
    output logic              dreq,
    output logic [DATA_W-1:0] dma_data,
    output logic              cfg_en,
    output logic              eot_flag,
    output logic              eot_pulse,
    output logic [2:0]        eot_cause,
    output logic [CNT_W-1:0]  bytes_left
);
    typedef struct packed {
        logic             en;
        logic             cnt_en;
        logic             short_en;
        logic [CNT_W-1:0] cnt_reg;
        logic             eot;
        eot_cause_t       cause;
        logic             pulse;
    } ctl_st_t;

    ctl_st_t    st_d, st_q;
    dma_cfg_t   wcfg;
    logic       rise, sw_stop, beat, fire;
    logic       cnt_zero, cnt_one;
    logic       has_data, last_short, zlp_short;
    eot_cause_t cause_now;

    assign wcfg    = dma_cfg_t'(cfg_wdata);
    assign rise    = cfg_we && wcfg.en && !st_q.en;
    assign sw_stop = cfg_we && !wcfg.en && st_q.en;

    assign dreq     = st_q.en && has_data && !(st_q.cnt_en && cnt_zero);
    assign beat     = dack && dreq;
    assign buf_pop  = beat;
    assign dma_data = beat ? buf_rdata : '0;

    dma_byte_cnt #(.CNT_W(CNT_W)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rise),
        .load_val (st_q.cnt_reg),
        .dec      (beat),
        .count    (bytes_left),
        .is_zero  (cnt_zero),
        .is_one   (cnt_one)
    );

    dma_pkt_track #(.MAX_PKT(MAX_PKT), .LEN_W(LEN_W)) i_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .pkt_valid  (pkt_valid),
        .pkt_len    (pkt_len),
        .take       (beat),
        .has_data   (has_data),
        .last_short (last_short),
        .zlp_short  (zlp_short)
    );

    dma_eot_decide i_dec (
        .active     (st_q.en),
        .cnt_en     (st_q.cnt_en),
        .short_en   (st_q.short_en),
        .sw_stop    (sw_stop),
        .beat       (beat),
        .cnt_zero   (cnt_zero),
        .cnt_one    (cnt_one),
        .last_short (last_short),
        .zlp_short  (zlp_short),
        .cause      (cause_now),
        .fire       (fire)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = fire;
        if (cnt_we) begin
            st_d.cnt_reg = cnt_wdata;
        end
        if (cfg_we) begin
            st_d.en       = wcfg.en;
            st_d.cnt_en   = wcfg.cnt_en;
            st_d.short_en = wcfg.short_en;
        end
        if (fire) begin
            st_d.en    = 1'b0;
            st_d.eot   = 1'b1;
            st_d.cause = cause_now;
        end else if (eot_clr) begin
            st_d.eot   = 1'b0;
            st_d.cause = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_en    = st_q.en;
    assign eot_flag  = st_q.eot;
    assign eot_pulse = st_q.pulse;
    assign eot_cause = st_q.cause;
endmodule

// File: rtl/dma_eot_chk.sv
`timescale 1ns/1ps
module dma_eot_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dreq,
    input logic             buf_pop,
    input logic             cfg_en,
    input logic             eot_clr,
    input logic             eot_flag,
    input logic             eot_pulse,
    input logic [2:0]       eot_cause,
    input logic [CNT_W-1:0] bytes_left
);
    // R5: request and enable are gone when the end is reported
    a_r5_stop_on_eot: assert property (@(posedge clk) disable iff (!rst_n)
        eot_pulse |-> (!dreq && !cfg_en));

    // R11: the end pulse lasts one cycle
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        eot_pulse |=> !eot_pulse);

    // R12: a pulse always leaves a flag and a cause behind
    a_r12_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        eot_pulse |-> (eot_flag && (eot_cause != 3'b000)));

    // R12: flag holds until cleared
    a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (eot_flag && !eot_clr) |=> eot_flag);

    // R4: every moved byte steps the counter by one
    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        buf_pop |=> (bytes_left == CNT_W'($past(bytes_left) - CNT_W'(1))));

    // R2: an armed transfer with no byte moved keeps its count
    a_r2_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && !buf_pop) |=> $stable(bytes_left));
endmodule

bind dma_eot_ctrl dma_eot_chk #(.CNT_W(CNT_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dreq       (dreq),
    .buf_pop    (buf_pop),
    .cfg_en     (cfg_en),
    .eot_clr    (eot_clr),
    .eot_flag   (eot_flag),
    .eot_pulse  (eot_pulse),
    .eot_cause  (eot_cause),
    .bytes_left (bytes_left)
);

// File: tb/test_dma_eot_ctrl.sv
`timescale 1ns/1ps
module test_dma_eot_ctrl;
    localparam int CNT_W = 16;
    localparam int LEN_W = 7;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cfg_we, cnt_we, eot_clr, pkt_valid, dack;
    logic [2:0]       cfg_wdata;
    logic [CNT_W-1:0] cnt_wdata;
    logic [LEN_W-1:0] pkt_len;
    logic [7:0]       buf_rdata;
    logic             buf_pop, dreq, cfg_en, eot_flag, eot_pulse;
    logic [7:0]       dma_data;
    logic [2:0]       eot_cause;
    logic [CNT_W-1:0] bytes_left;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dma_eot_ctrl i_dma_eot_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .eot_clr(eot_clr),
        .pkt_valid(pkt_valid), .pkt_len(pkt_len), .buf_rdata(buf_rdata),
        .buf_pop(buf_pop), .dack(dack), .dreq(dreq), .dma_data(dma_data),
        .cfg_en(cfg_en), .eot_flag(eot_flag), .eot_pulse(eot_pulse),
        .eot_cause(eot_cause), .bytes_left(bytes_left)
    );

    typedef struct packed {
        logic [15:0] cnt;
        logic        ce;
        logic        se;
        logic [6:0]  plen;
        logic [7:0]  moved;
        logic [2:0]  cause;
        logic        gap;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{16'd5,   1'b1, 1'b0, 7'd64, 8'd5,  3'b001, 1'b0},
        '{16'd100, 1'b0, 1'b1, 7'd10, 8'd10, 3'b010, 1'b1},
        '{16'd10,  1'b1, 1'b1, 7'd10, 8'd10, 3'b011, 1'b0},
        '{16'd3,   1'b1, 1'b1, 7'd10, 8'd3,  3'b001, 1'b1},
        '{16'd12,  1'b1, 1'b1, 7'd64, 8'd12, 3'b001, 1'b0},
        '{16'd70,  1'b1, 1'b1, 7'd64, 8'd70, 3'b001, 1'b1},
        '{16'd1,   1'b1, 1'b0, 7'd64, 8'd1,  3'b001, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cfg_we = 0; cnt_we = 0; eot_clr = 0; pkt_valid = 0; dack = 0;
        cfg_wdata = '0; cnt_wdata = '0; pkt_len = '0; buf_rdata = '0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic wr_cnt(input int v);
        cnt_we = 1'b1; cnt_wdata = CNT_W'(v);
        tick();
        cnt_we = 1'b0;
    endtask

    task automatic wr_cfg(input bit se, input bit ce, input bit en);
        cfg_we = 1'b1; cfg_wdata = {se, ce, en};
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic put_pkt(input int len);
        pkt_valid = 1'b1; pkt_len = LEN_W'(len);
        tick();
        pkt_valid = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int rem, moved, pulses, cyc;
        bit done, pop, strobe;
        do_reset();
        wr_cnt(int'(v.cnt));
        wr_cfg(v.se, v.ce, 1'b1);
        rem = 0; moved = 0; pulses = 0; cyc = 0; done = 0;
        while (!done && cyc < 400) begin
            strobe    = (rem == 0);
            pkt_valid = strobe;
            pkt_len   = v.plen;
            dack      = v.gap ? (cyc % 2 == 0) : 1'b1;
            buf_rdata = 8'(cyc + 3);
            #2;
            pop = buf_pop;
            if (pop) chk(dma_data == buf_rdata, "R4 data", int'(dma_data), int'(buf_rdata));
            tick();
            if (pop) begin rem--; moved++; end
            if (strobe) rem = int'(v.plen);
            if (eot_pulse) pulses++;
            if (eot_flag) done = 1;
            cyc++;
        end
        pkt_valid = 0; dack = 0;
        chk(dreq == 1'b0 && cfg_en == 1'b0, "R5 stop", int'({dreq, cfg_en}), 0);
        tick();
        if (eot_pulse) pulses++;
        chk(moved == int'(v.moved), $sformatf("R5/R8 vec%0d bytes", idx), moved, int'(v.moved));
        chk(eot_cause == v.cause, $sformatf("R11 vec%0d cause", idx), int'(eot_cause), int'(v.cause));
        chk(pulses == 1, $sformatf("R11 vec%0d pulses", idx), pulses, 1);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int pops;
        do_reset();
        // R1
        chk({dreq, eot_flag, eot_pulse, cfg_en} == 4'b0 && eot_cause == 3'b0 && bytes_left == '0,
            "R1 reset", int'({dreq, eot_flag, eot_pulse, cfg_en, eot_cause}), 0);

        for (int i = 0; i < 7; i++) run_vec(VECS[i], i);

        // R2 load on rise only
        do_reset();
        wr_cnt(7);
        wr_cfg(0, 0, 1);
        chk(bytes_left == 16'd7, "R2 load", int'(bytes_left), 7);
        chk(dreq == 1'b0, "R3 no data", int'(dreq), 0);
        wr_cnt(3);
        wr_cfg(0, 0, 1);
        chk(bytes_left == 16'd7, "R2 no reload", int'(bytes_left), 7);

        // R3 / R4
        put_pkt(4);
        chk(dreq == 1'b1, "R3 dreq", int'(dreq), 1);
        tick();
        chk(bytes_left == 16'd7, "R4 idle", int'(bytes_left), 7);
        dack = 1'b1; buf_rdata = 8'hA5;
        #1;
        chk(buf_pop == 1'b1 && dma_data == 8'hA5, "R4 beat", int'({buf_pop, dma_data}), 'h1A5);
        tick();
        chk(bytes_left == 16'd6, "R4 step", int'(bytes_left), 6);

        // R9 second strobe while bytes remain
        dack = 1'b0;
        put_pkt(2);
        dack = 1'b1; pops = 0;
        for (int k = 0; k < 6; k++) begin
            #1; if (buf_pop) pops++;
            tick();
        end
        chk(pops == 3, "R9 ignored strobe", pops, 3);
        chk(dreq == 1'b0 && bytes_left == 16'd3, "R9 drained", int'(bytes_left), 3);
        #1;
        chk(buf_pop == 1'b0, "R4 dack ignored", int'(buf_pop), 0);
        tick();
        chk(bytes_left == 16'd3, "R4 dack no count", int'(bytes_left), 3);
        dack = 1'b0;

        // R10 software stop
        put_pkt(5);
        wr_cfg(0, 0, 0);
        chk(eot_flag && eot_cause == 3'b100, "R10 sw stop", int'(eot_cause), 4);
        chk(dreq == 1'b0 && cfg_en == 1'b0, "R10 idle", int'({dreq, cfg_en}), 0);

        // R12 sticky and clear
        tick(); tick();
        chk(eot_flag == 1'b1, "R12 sticky", int'(eot_flag), 1);
        eot_clr = 1'b1; tick(); eot_clr = 1'b0;
        chk(eot_flag == 1'b0 && eot_cause == 3'b0, "R12 clear", int'({eot_flag, eot_cause}), 0);

        // R6 counter wraps without end
        wr_cnt(1);
        wr_cfg(0, 0, 1);
        dack = 1'b1;
        for (int k = 0; k < 6; k++) tick();
        dack = 1'b0;
        chk(bytes_left == 16'hFFFC && !eot_flag, "R6 wrap", int'(bytes_left), 'hFFFC);

        // R7 zero count
        do_reset();
        put_pkt(5);
        wr_cnt(0);
        wr_cfg(0, 1, 1);
        chk(cfg_en && !dreq && !eot_flag, "R7 armed no dreq", int'({cfg_en, dreq, eot_flag}), 4);
        tick();
        chk(eot_flag && eot_cause == 3'b001 && !dreq, "R7 immediate", int'(eot_cause), 1);

        // R8 zero-length short packet
        do_reset();
        wr_cfg(1, 0, 1);
        put_pkt(0);
        chk(eot_flag && eot_cause == 3'b010, "R8 zlp", int'(eot_cause), 2);

        // R12 set wins over clear
        do_reset();
        wr_cfg(0, 0, 1);
        eot_clr = 1'b1;
        wr_cfg(0, 0, 0);
        eot_clr = 1'b0;
        chk(eot_flag == 1'b1, "R12 set wins", int'(eot_flag), 1);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule